// File: doc/BRIEF.md
# Frequency-Control Register Target on a Two-Wire Serial Bus

This block is the device side of an I2C link for a programmable clock synthesizer. It keeps the synthesizer's frequency settings in a small register bank: a three-bit high-speed divider code, a seven-bit output divider field, a 38-bit fractional multiplier, a control byte and a freeze byte. It sends these settings to the synthesizer as registered outputs. SCL and SDA are oversampled by the system clock. The block finds START, repeated START and STOP, takes a byte pointer after its own address, and steps that pointer after every data byte. It pulls the open-drain data line low through an enable output.

A controller first sends a pointer and some data bytes to write. To read, it sends a pointer, then a repeated START with the read bit set, and then reads bytes. While the multiplier freeze bit is set, the exported multiplier word holds its old value. Byte-by-byte writes to the multiplier therefore reach the synthesizer as one change when the freeze bit is cleared. Two control bits clear themselves. One of them produces a single-cycle "apply new frequency" strobe. The other reloads the power-on divider and multiplier values.

Top module: `fsynth_i2c_regs`

## Requirements
- R1: A transaction whose 7-bit address equals DEV_ADDR (write bit 0) is acknowledged. The next byte is taken as the register pointer, and every following byte is acknowledged and written to the register the pointer selects.
- R2: A transaction carrying any other address is not acknowledged (SDA stays high in the acknowledge slot) and changes no register or output.
- R3: After a repeated START with the read bit 1, the block drives register data MSB first, starting at the pointer. A controller NACK ends the transmission: SDA is released and stays released until the next START.
- R4: The pointer steps by one after every byte written or read, so multi-byte writes and reads cover consecutive registers.
- R5: Pointer 7 holds the divider code in bits 7:5 and output divider field bits 6:2 in bits 4:0. Pointer 8 holds output divider field bits 1:0 in bits 7:6 and multiplier bits 37:32 in bits 5:0.
- R6: hs_ratio_o decodes the divider code as 000→4, 001→5, 010→6, 011→7, 101→9, 111→11. The unused codes 100 and 110 give 0.
- R7: n1_ratio_o is the output divider field plus one, except that an odd result above 1 is raised to the next even value (field 0→1, 4→6, 127→128).
- R8: Pointers 9, 10, 11 and 12 hold multiplier bits 31:24, 23:16, 15:8 and 7:0.
- R9: While control bit 5 (pointer 135) is 1, mult_o keeps its value. When that bit returns to 0, mult_o takes the stored multiplier.
- R10: Writing 1 to control bit 6 gives exactly one newfreq_o pulse one cycle long, and the bit then reads back 0.
- R11: Writing 1 to control bit 0 reloads the divider code, divider field and multiplier with their power-on values, gives one recall_o pulse one cycle long, and the bit then reads back 0.
- R12: Control bit 4 is stored and drives freeze_aux_o. Control bits 7 and 3:1 read 0. Pointer 137 bit 4 drives freeze_dco_o, and its other bits read 0 whatever is written.
- R13: An access to any other pointer is acknowledged. A write to it has no effect, and a read of it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| mult_o | output | 38 | Multiplier word, held while frozen |
| hs_ratio_o | output | 4 | Decoded high-speed divide ratio |
| n1_ratio_o | output | 8 | Decoded output divide ratio |
| newfreq_o | output | 1 | One-cycle apply-new-frequency strobe |
| recall_o | output | 1 | One-cycle defaults-reload strobe |
| freeze_aux_o | output | 1 | Auxiliary freeze bit |
| freeze_dco_o | output | 1 | Oscillator freeze bit |

## Verification
The bench writes multiplier bytes while frozen and checks every clock that mult_o does not move. A design without the shadow would let the synthesizer see half-updated words. A read is ended with a NACK and then clocked on. A target that ignored the NACK would pull SDA low and corrupt the controller's STOP. The divider decode is tested on the unused codes and on the odd, zero and largest N1 fields, where an off-by-one or a missing round-up gives a ratio that is wrong or odd. The tests also cover a foreign address, pointers that are not mapped, and the reserved control bits, where a decode that is too loose would acknowledge, store or return stray bits.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int MULT_W = 38;
  localparam int BYTE_W = 8;
  localparam int LOW_BYTES = (MULT_W - 6) / BYTE_W;

  localparam logic [7:0] PTR_DIV  = 8'd7;
  localparam logic [7:0] PTR_MHI  = 8'd8;
  localparam logic [7:0] PTR_MLSB = 8'd12;
  localparam logic [7:0] PTR_CTL  = 8'd135;
  localparam logic [7:0] PTR_FRZ  = 8'd137;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_TX, ST_TXACK, ST_TXWAIT
  } bus_st_e;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} rx_kind_e;

  function automatic logic [3:0] hs_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return 4'd4;
      3'd1:    return 4'd5;
      3'd2:    return 4'd6;
      3'd3:    return 4'd7;
      3'd5:    return 4'd9;
      3'd7:    return 4'd11;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [7:0] n1_ratio(input logic [6:0] fld);
    if (fld == 7'd0)  return 8'd1;
    else if (fld[0])  return {1'b0, fld} + 8'd1;
    else              return {1'b0, fld} + 8'd2;
  endfunction
endpackage

// File: rtl/fsr_line_sync.sv
module fsr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_pipe, sda_pipe;
  logic [DEPTH-1:0] scl_pipe_d, sda_pipe_d;
  logic scl_s, scl_q, sda_s, sda_q;

  always_comb begin
    scl_pipe_d = {scl_pipe[DEPTH-2:0], scl_i};
    sda_pipe_d = {sda_pipe[DEPTH-2:0], sda_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= scl_pipe_d;
      sda_pipe <= sda_pipe_d;
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign scl_q = scl_pipe[STAGES];
  assign sda_s = sda_pipe[STAGES-1];
  assign sda_q = sda_pipe[STAGES];

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/fsr_bus_ctrl.sv
module fsr_bus_ctrl
  import fsr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h55
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] rd_addr_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  bus_st_e    st_q, st_d;
  rx_kind_e   kind_q, kind_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] tx_q, tx_d;
  logic [7:0] ptr_q, ptr_d;
  logic       rw_q, rw_d;
  logic       oe_q, oe_d;
  logic       we_q, we_d;
  logic [7:0] wa_q, wa_d;
  logic [7:0] wd_q, wd_d;

  always_comb begin
    st_d = st_q; kind_d = kind_q; bit_d = bit_q; sh_d = sh_q; tx_d = tx_q;
    ptr_d = ptr_q; rw_d = rw_q; oe_d = oe_q; we_d = 1'b0; wa_d = wa_q; wd_d = wd_q;
    if (stop_i) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_i) begin
      st_d   = ST_RX;
      kind_d = K_ADDR;
      bit_d  = 3'd0;
      oe_d   = 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: ;
        ST_RX: if (scl_rise_i) begin
          sh_d  = {sh_q[6:0], sda_i};
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) st_d = ST_RXEND;
        end
        ST_RXEND: if (scl_fall_i) begin
          st_d = ST_ACK;
          oe_d = 1'b1;
          case (kind_q)
            K_ADDR: begin
              if (sh_q[7:1] == DEV_ADDR) rw_d = sh_q[0];
              else begin
                st_d = ST_IDLE;
                oe_d = 1'b0;
              end
            end
            K_PTR: ptr_d = sh_q;
            default: begin
              we_d  = 1'b1;
              wa_d  = ptr_q;
              wd_d  = sh_q;
              ptr_d = ptr_q + 8'd1;
            end
          endcase
        end
        ST_ACK: if (scl_fall_i) begin
          bit_d = 3'd0;
          if (rw_q) begin
            st_d  = ST_TX;
            tx_d  = rd_data_i;
            ptr_d = ptr_q + 8'd1;
            oe_d  = ~rd_data_i[7];
          end else begin
            st_d   = ST_RX;
            kind_d = (kind_q == K_ADDR) ? K_PTR : K_DATA;
            oe_d   = 1'b0;
          end
        end
        ST_TX: if (scl_fall_i) begin
          if (bit_q == 3'd7) begin
            st_d = ST_TXACK;
            oe_d = 1'b0;
          end else begin
            bit_d = bit_q + 3'd1;
            tx_d  = {tx_q[6:0], 1'b0};
            oe_d  = ~tx_q[6];
          end
        end
        ST_TXACK: if (scl_rise_i) st_d = sda_i ? ST_IDLE : ST_TXWAIT;
        ST_TXWAIT: if (scl_fall_i) begin
          st_d  = ST_TX;
          bit_d = 3'd0;
          tx_d  = rd_data_i;
          ptr_d = ptr_q + 8'd1;
          oe_d  = ~rd_data_i[7];
        end
        default: begin
          st_d = ST_IDLE;
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; kind_q <= K_ADDR; bit_q <= '0; sh_q <= '0; tx_q <= '0;
      ptr_q <= '0; rw_q <= 1'b0; oe_q <= 1'b0; we_q <= 1'b0; wa_q <= '0; wd_q <= '0;
    end else begin
      st_q <= st_d; kind_q <= kind_d; bit_q <= bit_d; sh_q <= sh_d; tx_q <= tx_d;
      ptr_q <= ptr_d; rw_q <= rw_d; oe_q <= oe_d; we_q <= we_d; wa_q <= wa_d; wd_q <= wd_d;
    end
  end

  assign rd_addr_o = ptr_q;
  assign wr_en_o   = we_q;
  assign wr_addr_o = wa_q;
  assign wr_data_o = wd_q;
  assign sda_oe_o  = oe_q;
endmodule

// File: rtl/fsr_regbank.sv
module fsr_regbank
  import fsr_pkg::*;
#(
  parameter logic [2:0]        DEF_HS   = 3'd3,
  parameter logic [6:0]        DEF_N1   = 7'd3,
  parameter logic [MULT_W-1:0] DEF_MULT = 38'h2A_DEAD_BEEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [7:0]        rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [2:0]        hs_code_o,
  output logic [6:0]        n1_fld_o,
  output logic [MULT_W-1:0] mult_raw_o,
  output logic              frz_m_o,
  output logic              frz_aux_o,
  output logic              frz_dco_o,
  output logic              newfreq_o,
  output logic              recall_o
);
  logic [2:0]        hs_q, hs_d;
  logic [6:0]        n1_q, n1_d;
  logic [MULT_W-1:0] mf_q, mf_d;
  logic nf_q, nf_d, fm_q, fm_d, fa_q, fa_d, rc_q, rc_d, fd_q, fd_d;
  logic wr_ok;

  assign wr_ok = wr_en_i & ~rc_q;

  always_comb begin
    hs_d = hs_q; n1_d = n1_q; mf_d = mf_q;
    fm_d = fm_q; fa_d = fa_q; fd_d = fd_q;
    nf_d = 1'b0;
    rc_d = 1'b0;
    if (rc_q) begin
      hs_d = DEF_HS;
      n1_d = DEF_N1;
      mf_d = DEF_MULT;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        PTR_DIV: {hs_d, n1_d[6:2]} = wr_data_i;
        PTR_MHI: begin
          n1_d[1:0]               = wr_data_i[7:6];
          mf_d[MULT_W-1:MULT_W-6] = wr_data_i[5:0];
        end
        PTR_CTL: begin
          nf_d = wr_data_i[6];
          fm_d = wr_data_i[5];
          fa_d = wr_data_i[4];
          rc_d = wr_data_i[0];
        end
        PTR_FRZ: fd_d = wr_data_i[4];
        default: ;
      endcase
    end
    for (int b = 0; b < LOW_BYTES; b++) begin
      if (wr_ok && wr_addr_i == PTR_MLSB - 8'(b))
        mf_d[BYTE_W*b +: BYTE_W] = wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= DEF_HS; n1_q <= DEF_N1; mf_q <= DEF_MULT;
      nf_q <= 1'b0; fm_q <= 1'b0; fa_q <= 1'b0; rc_q <= 1'b0; fd_q <= 1'b0;
    end else begin
      hs_q <= hs_d; n1_q <= n1_d; mf_q <= mf_d;
      nf_q <= nf_d; fm_q <= fm_d; fa_q <= fa_d; rc_q <= rc_d; fd_q <= fd_d;
    end
  end

  always_comb begin
    case (rd_addr_i)
      PTR_DIV: rd_data_o = {hs_q, n1_q[6:2]};
      PTR_MHI: rd_data_o = {n1_q[1:0], mf_q[MULT_W-1:MULT_W-6]};
      PTR_CTL: rd_data_o = {1'b0, nf_q, fm_q, fa_q, 3'b000, rc_q};
      PTR_FRZ: rd_data_o = {3'b000, fd_q, 4'b0000};
      default: rd_data_o = 8'h00;
    endcase
    for (int b = 0; b < LOW_BYTES; b++) begin
      if (rd_addr_i == PTR_MLSB - 8'(b)) rd_data_o = mf_q[BYTE_W*b +: BYTE_W];
    end
  end

  assign hs_code_o  = hs_q;
  assign n1_fld_o   = n1_q;
  assign mult_raw_o = mf_q;
  assign frz_m_o    = fm_q;
  assign frz_aux_o  = fa_q;
  assign frz_dco_o  = fd_q;
  assign newfreq_o  = nf_q;
  assign recall_o   = rc_q;
endmodule

// File: rtl/fsr_out_stage.sv
module fsr_out_stage
  import fsr_pkg::*;
#(
  parameter logic [2:0]        DEF_HS   = 3'd3,
  parameter logic [6:0]        DEF_N1   = 7'd3,
  parameter logic [MULT_W-1:0] DEF_MULT = 38'h2A_DEAD_BEEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        hs_code_i,
  input  logic [6:0]        n1_fld_i,
  input  logic [MULT_W-1:0] mult_raw_i,
  input  logic              frz_m_i,
  output logic [MULT_W-1:0] mult_o,
  output logic [3:0]        hs_ratio_o,
  output logic [7:0]        n1_ratio_o
);
  logic [MULT_W-1:0] mult_q, mult_d;
  logic [3:0]        hs_q, hs_d;
  logic [7:0]        n1_q, n1_d;
  logic              mult_en;

  assign mult_en = ~frz_m_i;

  always_comb begin
    mult_d = mult_en ? mult_raw_i : mult_q;
    hs_d   = hs_ratio(hs_code_i);
    n1_d   = n1_ratio(n1_fld_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mult_q <= DEF_MULT;
      hs_q   <= hs_ratio(DEF_HS);
      n1_q   <= n1_ratio(DEF_N1);
    end else begin
      mult_q <= mult_d;
      hs_q   <= hs_d;
      n1_q   <= n1_d;
    end
  end

  assign mult_o     = mult_q;
  assign hs_ratio_o = hs_q;
  assign n1_ratio_o = n1_q;
endmodule

// File: rtl/fsynth_i2c_regs.sv
module fsynth_i2c_regs
  import fsr_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h55,
  parameter int                SYNC_STAGES = 2,
  parameter logic [2:0]        DEF_HS      = 3'd3,
  parameter logic [6:0]        DEF_N1      = 7'd3,
  parameter logic [MULT_W-1:0] DEF_MULT    = 38'h2A_DEAD_BEEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [3:0]        hs_ratio_o,
  output logic [7:0]        n1_ratio_o,
  output logic              newfreq_o,
  output logic              recall_o,
  output logic              freeze_aux_o,
  output logic              freeze_dco_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic       wr_en;
  logic [2:0] hs_code;
  logic [6:0] n1_fld;
  logic [MULT_W-1:0] mult_raw;
  logic       frz_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  fsr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  fsr_bus_ctrl #(.DEV_ADDR(DEV_ADDR)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_n), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sda_oe_o(sda_oe_o)
  );

  fsr_regbank #(.DEF_HS(DEF_HS), .DEF_N1(DEF_N1), .DEF_MULT(DEF_MULT)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .hs_code_o(hs_code), .n1_fld_o(n1_fld), .mult_raw_o(mult_raw),
    .frz_m_o(frz_m), .frz_aux_o(freeze_aux_o), .frz_dco_o(freeze_dco_o),
    .newfreq_o(newfreq_o), .recall_o(recall_o)
  );

  fsr_out_stage #(.DEF_HS(DEF_HS), .DEF_N1(DEF_N1), .DEF_MULT(DEF_MULT)) u_out (
    .clk_i(clk_i), .rst_ni(rst_n),
    .hs_code_i(hs_code), .n1_fld_i(n1_fld), .mult_raw_i(mult_raw), .frz_m_i(frz_m),
    .mult_o(mult_o), .hs_ratio_o(hs_ratio_o), .n1_ratio_o(n1_ratio_o)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
  parameter int MW = 38
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stop_det,
  input logic          sda_oe_o,
  input logic          newfreq_o,
  input logic          recall_o,
  input logic          frz_m,
  input logic [MW-1:0] mult_o,
  input logic [3:0]    hs_ratio_o,
  input logic [7:0]    n1_ratio_o
);
  assert_newfreq_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    newfreq_o |=> !newfreq_o);

  assert_recall_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |=> !recall_o);

  assert_mult_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frz_m) |-> $stable(mult_o));

  assert_hs_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_ratio_o inside {4'd0, 4'd4, 4'd5, 4'd6, 4'd7, 4'd9, 4'd11});

  assert_n1_even_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n1_ratio_o == 8'd1) || (n1_ratio_o != 8'd0 && !n1_ratio_o[0]));

  assert_release_on_stop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);
endmodule

bind fsynth_i2c_regs fsr_checker #(.MW(fsr_pkg::MULT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .stop_det(stop_det), .sda_oe_o(sda_oe_o),
  .newfreq_o(newfreq_o), .recall_o(recall_o), .frz_m(frz_m), .mult_o(mult_o),
  .hs_ratio_o(hs_ratio_o), .n1_ratio_o(n1_ratio_o)
);

// File: tb/fsynth_i2c_regs_tb_top.sv
`timescale 1ns/1ps
module fsynth_i2c_regs_tb_top;
  localparam logic [6:0] ADDR = 7'h55;
  localparam logic [2:0] D_HS = 3'd3;
  localparam logic [6:0] D_N1 = 7'd3;
  localparam logic [37:0] D_MF = 38'h2A_DEAD_BEEF;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_low = 1'b0;
  wire  sda_line;
  logic sda_oe;
  logic [37:0] mult;
  logic [3:0]  hs_ratio;
  logic [7:0]  n1_ratio;
  logic newfreq, recall, frz_aux, frz_dco;

  always #4 clk = ~clk;
  assign sda_line = !(sda_low || sda_oe);

  fsynth_i2c_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .mult_o(mult), .hs_ratio_o(hs_ratio), .n1_ratio_o(n1_ratio),
    .newfreq_o(newfreq), .recall_o(recall), .freeze_aux_o(frz_aux), .freeze_dco_o(frz_dco)
  );

  int compared = 0, mismatched = 0;
  int nf_seen = 0, rc_seen = 0, nf_exp = 0, rc_exp = 0;
  bit cmp_en = 0, finished = 0;

  // behavioural model state
  logic [2:0] m_hs; logic [6:0] m_n1; logic [37:0] m_mf, m_mult;
  logic m_fm, m_fa, m_fd;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int exp_hs(input logic [2:0] c);
    case (c)
      3'd0: return 4; 3'd1: return 5; 3'd2: return 6; 3'd3: return 7;
      3'd5: return 9; 3'd7: return 11; default: return 0;
    endcase
  endfunction

  function automatic int exp_n1(input logic [6:0] f);
    int r = int'(f) + 1;
    if (r > 1 && (r % 2) == 1) r = r + 1;
    return r;
  endfunction

  function automatic logic [7:0] mread(input logic [7:0] a);
    if (a == 8'd7)  return {m_hs, m_n1[6:2]};
    if (a == 8'd8)  return {m_n1[1:0], m_mf[37:32]};
    if (a >= 8'd9 && a <= 8'd12) return m_mf[(12 - int'(a)) * 8 +: 8];
    if (a == 8'd135) return {2'b00, m_fm, m_fa, 4'b0000};
    if (a == 8'd137) return {3'b000, m_fd, 4'b0000};
    return 8'h00;
  endfunction

  task automatic m_reset();
    m_hs = D_HS; m_n1 = D_N1; m_mf = D_MF; m_mult = D_MF;
    m_fm = 0; m_fa = 0; m_fd = 0;
  endtask

  task automatic mwrite(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'd7) begin m_hs = d[7:5]; m_n1[6:2] = d[4:0]; end
    else if (a == 8'd8) begin m_n1[1:0] = d[7:6]; m_mf[37:32] = d[5:0]; end
    else if (a >= 8'd9 && a <= 8'd12) m_mf[(12 - int'(a)) * 8 +: 8] = d;
    else if (a == 8'd135) begin
      m_fm = d[5]; m_fa = d[4];
      if (d[6]) nf_exp++;
      if (d[0]) begin rc_exp++; m_hs = D_HS; m_n1 = D_N1; m_mf = D_MF; end
    end else if (a == 8'd137) m_fd = d[4];
    if (!m_fm) m_mult = m_mf;
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (newfreq) nf_seen++;
    if (recall)  rc_seen++;
    if (cmp_en) begin
      chk("R9 mult_o", 64'(mult), 64'(m_mult));
      chk("R6 hs_ratio_o", 64'(hs_ratio), 64'(exp_hs(m_hs)));
      chk("R7 n1_ratio_o", 64'(n1_ratio), 64'(exp_n1(m_n1)));
      chk("R12 freeze_dco_o", 64'(frz_dco), 64'(m_fd));
      chk("R12 freeze_aux_o", 64'(frz_aux), 64'(m_fa));
    end
  end

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_low = 0; wt(HP); scl_m = 1; wt(HP); sda_low = 1; wt(HP); scl_m = 0; wt(HP);
  endtask
  task automatic bus_stop();
    wt(2); sda_low = 1; wt(HP); scl_m = 1; wt(HP); sda_low = 0; wt(HP);
  endtask
  task automatic put_bit(input logic b);
    wt(2); sda_low = !b; wt(HP); scl_m = 1; wt(HP); scl_m = 0;
  endtask
  task automatic get_bit(output logic b);
    wt(2); sda_low = 0; wt(HP); scl_m = 1; wt(HP / 2); b = sda_line; wt(HP - HP / 2); scl_m = 0;
  endtask
  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    acked = !a;
  endtask
  task automatic recv_byte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(last);
  endtask

  task automatic settle();
    wt(12); cmp_en = 1;
  endtask

  // R1 R4: write n bytes from ptr; model applied after the transaction
  task automatic wr_regs(input logic [7:0] ptr, input logic [7:0] d [8], input int n);
    logic ak;
    cmp_en = 0;
    bus_start();
    send_byte({ADDR, 1'b0}, ak); chk("R1 address ack", 64'(ak), 64'd1);
    send_byte(ptr, ak);          chk("R1 pointer ack", 64'(ak), 64'd1);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], ak); chk("R1 data ack", 64'(ak), 64'd1);
    end
    bus_stop();
    for (int k = 0; k < n; k++) mwrite(ptr + 8'(k), d[k]);
    settle();
  endtask

  // R3 R4: read n bytes from ptr, compare with model
  task automatic rd_check(input logic [7:0] ptr, input int n, input string tag);
    logic ak; logic [7:0] v;
    cmp_en = 0;
    bus_start();
    send_byte({ADDR, 1'b0}, ak); chk("R1 address ack", 64'(ak), 64'd1);
    send_byte(ptr, ak);          chk("R1 pointer ack", 64'(ak), 64'd1);
    bus_start();
    send_byte({ADDR, 1'b1}, ak); chk("R3 read address ack", 64'(ak), 64'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, v);
      chk(tag, 64'(v), 64'(mread(ptr + 8'(k))));
    end
    bus_stop();
    settle();
  endtask

  logic [7:0] buf8 [8];

  initial begin
    logic ak; logic [7:0] v;
    logic [37:0] held;
    m_reset();
    wt(5); rst_n = 1; wt(6);
    chk("R1 reset sda_oe_o", 64'(sda_oe), 64'd0);
    chk("R6 reset newfreq_o", 64'(newfreq), 64'd0);
    cmp_en = 1; wt(4);
    rd_check(8'd7, 6, "R3 R5 R8 reset readback");

    // R5 R8 R4: full configuration in one burst
    buf8 = '{8'hA3, 8'h6E, 8'h12, 8'h34, 8'h56, 8'h78, 8'h00, 8'h00};
    wr_regs(8'd7, buf8, 6);
    chk("R5 R8 mult_o after burst", 64'(mult), 64'h2E_1234_5678);
    chk("R7 n1 field 13", 64'(n1_ratio), 64'd14);
    rd_check(8'd7, 6, "R4 R5 R8 burst readback");

    // R6 R7: unused divider codes and N1 corner fields
    buf8 = '{8'h80, 8'h15, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd7, buf8, 2);
    chk("R6 code 100 gives 0", 64'(hs_ratio), 64'd0);
    chk("R7 field 0 gives 1", 64'(n1_ratio), 64'd1);
    buf8 = '{8'hC1, 8'h15, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd7, buf8, 2);
    chk("R6 code 110 gives 0", 64'(hs_ratio), 64'd0);
    chk("R7 field 4 gives 6", 64'(n1_ratio), 64'd6);
    buf8 = '{8'h7F, 8'hD5, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd7, buf8, 2);
    chk("R7 field 127 gives 128", 64'(n1_ratio), 64'd128);
    buf8 = '{8'hE2, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd7, buf8, 2);
    chk("R6 code 111 gives 11", 64'(hs_ratio), 64'd11);
    chk("R7 field 9 gives 10", 64'(n1_ratio), 64'd10);

    // R2: foreign address is not acknowledged and changes nothing
    cmp_en = 0;
    bus_start();
    send_byte({7'h12, 1'b0}, ak); chk("R2 foreign address nack", 64'(ak), 64'd0);
    send_byte(8'd7, ak);          chk("R2 no ack after foreign address", 64'(ak), 64'd0);
    send_byte(8'h00, ak);
    bus_stop();
    settle();
    rd_check(8'd7, 2, "R2 registers unchanged");

    // R9: frozen multiplier update appears only on release
    held = m_mult;
    buf8 = '{8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd135, buf8, 1);
    buf8 = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd9, buf8, 4);
    chk("R9 mult_o held while frozen", 64'(mult), 64'(held));
    rd_check(8'd9, 4, "R8 stored bytes while frozen");
    buf8 = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd135, buf8, 1);
    chk("R9 mult_o copied on release", 64'(mult), {26'd0, 38'h00_DEAD_BEEF} | (64'(held) & 64'h3F_0000_0000));

    // R10: new-frequency strobe
    buf8 = '{8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd135, buf8, 1);
    chk("R10 one newfreq pulse", 64'(nf_seen), 64'(nf_exp));
    rd_check(8'd135, 1, "R10 control reads 0 after strobe");

    // R12: reserved control bits and the oscillator freeze byte
    buf8 = '{8'h9E, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd135, buf8, 1);
    rd_check(8'd135, 1, "R12 control reserved bits read 0");
    buf8 = '{8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd137, buf8, 1);
    chk("R12 freeze_dco_o set", 64'(frz_dco), 64'd1);
    rd_check(8'd137, 1, "R12 freeze byte reads only bit 4");
    buf8 = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd137, buf8, 1);
    wr_regs(8'd135, buf8, 1);

    // R13: unmapped pointer acknowledged, ignored, reads 0
    buf8 = '{8'hAB, 8'hCD, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd32, buf8, 2);
    rd_check(8'd32, 2, "R13 unmapped reads 0x00");
    rd_check(8'd11, 3, "R13 R4 read across map end");

    // R11: recall restores power-on values
    buf8 = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_regs(8'd135, buf8, 1);
    chk("R11 one recall pulse", 64'(rc_seen), 64'(rc_exp));
    chk("R11 mult_o default", 64'(mult), 64'(D_MF));
    rd_check(8'd7, 6, "R11 defaults read back");
    rd_check(8'd135, 1, "R11 recall bit reads 0");

    // R3: NACK ends the transmission
    cmp_en = 0;
    bus_start();
    send_byte({ADDR, 1'b0}, ak);
    send_byte(8'd9, ak);
    bus_start();
    send_byte({ADDR, 1'b1}, ak);
    recv_byte(1'b1, v);
    chk("R3 single byte before nack", 64'(v), 64'(mread(8'd9)));
    recv_byte(1'b1, v);
    chk("R3 line released after nack", 64'(v), 64'hFF);
    bus_stop();
    settle();
    chk("R10 no extra newfreq pulse", 64'(nf_seen), 64'(nf_exp));

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired R1 got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule